// File: doc/BRIEF.md
# Tag Fault Status Registers with Access Arbitration

The block keeps two small fault-status registers, one owned by the kernel privilege level and one by the hypervisor level. Each register holds two sticky flags that record asynchronous tag-check faults. The flag that sets depends on bit 55 of the faulting address. The flags build up until software overwrites them. A fault event carries a selector that names the register it lands in.

Software reaches the registers through three system-register encodings: the kernel-level name, an alias of it used from the hypervisor, and the hypervisor-level name. Every request passes through an ordered chain of permission checks. The checks look at the current privilege level (0 to 3), the feature-present flags, the hypervisor controls (host mode, three nested-virtualization bits, tag-access enable) and the secure-monitor controls. The chain returns a single outcome. A request is either undefined, trapped to level 2, trapped to level 3, redirected to a memory offset, or performed directly on one of the two registers. It may be remapped to the sibling register on the way. The decision is combinational. Register state changes only on a clock edge, and only for a direct write.

Top module: `tfs_top`

## Requirements
- R1: A request decodes only when op0=3, CRn=5, CRm=6 and op2=0. op1=0 selects the kernel name, op1=5 the alias and op1=4 the hypervisor name. Any other combination gives outcome UNDEF. Outcome codes are 0 IDLE, 1 UNDEF, 2 TRAP2, 3 TRAP3, 4 REDIR and 5 DIRECT.
- R2: When the asynchronous-fault feature flag is clear, every valid request is UNDEF. A request from level 0 is also UNDEF.
- R3: The kernel name from level 1 is checked in this order, and the first check that matches decides the outcome:
  - monitor present, monitor tag enable clear and monitor priority set gives UNDEF;
  - nested bits 011 give TRAP2;
  - level 2 enabled, host mode clear and hypervisor tag enable clear give TRAP2;
  - monitor present and monitor tag enable clear give UNDEF if the monitor undefined select is set, otherwise TRAP3;
  - nested bits 111 give REDIR;
  - otherwise the outcome is DIRECT on the kernel register.
- R4: The kernel name from level 2 first applies the monitor checks: monitor present and monitor tag enable clear give UNDEF if the priority or select bit is set, otherwise TRAP3. Otherwise it is DIRECT, on the hypervisor register in host mode and on the kernel register outside it. From level 3 the kernel name is always DIRECT on the kernel register.
- R5: The alias behaves as follows:
  - from level 1, nested bits 101 give REDIR, any other pattern with nested bit 0 set gives TRAP2, and every remaining pattern gives UNDEF;
  - from level 2, host mode clear gives UNDEF; in host mode the monitor checks apply, and otherwise the access is DIRECT on the kernel register;
  - from level 3, host mode gives DIRECT on the kernel register, and host mode clear gives UNDEF.
- R6: The hypervisor name behaves as follows:
  - from level 1 with nested bits 1x1, the checks run in this order: monitor priority UNDEF, then the hypervisor tag-enable TRAP2, then the monitor checks, and otherwise DIRECT on the kernel register;
  - from level 1 with another pattern that has nested bit 0 set, the outcome is TRAP2, and any remaining pattern gives UNDEF;
  - from level 2, the monitor checks apply first, and otherwise the access is DIRECT on the hypervisor register;
  - from level 3, the access is always DIRECT on the hypervisor register.
- R7: The syndrome output is 0x18 for TRAP2 and TRAP3 and 0 otherwise. The redirect offset is 0x190 for REDIR and 0 otherwise.
- R8: A fault event sets flag bit 1 when address bit 55 is 1 and flag bit 0 when it is 0. It lands in the kernel register when the selector is 0 and in the hypervisor register when it is 1. The flag is visible after the next clock edge, and earlier flags are kept.
- R9: A DIRECT write loads data bits 1:0 into the target register, and the upper data bits are ignored. A DIRECT read returns the flags zero-extended. Any other outcome leaves both registers unchanged and returns read data 0.
- R10: A fault event in the same cycle as a DIRECT write to the same register is ORed in after the write, so the fault flag is not lost.
- R11: Reset clears both registers. With no valid request, the outcome, syndrome, offset and read data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | Fault event strobe |
| flt_addr55 | input | 1 | Bit 55 of the faulting address |
| flt_sel | input | 1 | Target of the fault: 0 kernel register, 1 hypervisor register |
| req_valid | input | 1 | Software access request |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | DW | Write data |
| cur_lvl | input | 2 | Current privilege level |
| cfg_async | input | 1 | Asynchronous-fault feature present |
| cfg_lvl3 | input | 1 | Monitor level present |
| cfg_lvl2_en | input | 1 | Level 2 enabled |
| hyp_host | input | 1 | Hypervisor host mode |
| hyp_nest | input | 3 | Nested-virtualization bits |
| hyp_tag_en | input | 1 | Hypervisor tag-access enable |
| mon_tag_en | input | 1 | Monitor tag-access enable |
| mon_prio | input | 1 | Monitor undefined-priority control |
| mon_undef_sel | input | 1 | Monitor undefined (1) versus trap (0) select |
| rsp_outcome | output | 3 | Outcome code |
| rsp_syndrome | output | 6 | Trap syndrome class |
| rsp_redir_off | output | 12 | Redirect memory offset |
| rsp_rdata | output | DW | Read data |

## Verification
The flag assertions take for granted that the fault inputs are stable across each sampling edge. They also assume that a register changes only through a DIRECT write or a fault. The bench therefore drives every input on the falling edge and keeps fault strobes one cycle wide. The outcome sweep covers every combination of level, name and control bits with reads only and no fault events. Register contents are therefore fixed during the sweep, and the combinational outcome can be compared directly with the bench's own model.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  typedef enum logic [2:0] {
    OC_IDLE   = 3'd0,
    OC_UNDEF  = 3'd1,
    OC_TRAP2  = 3'd2,
    OC_TRAP3  = 3'd3,
    OC_REDIR  = 3'd4,
    OC_DIRECT = 3'd5
  } outcome_e;

  typedef enum logic [1:0] {
    NM_NONE  = 2'd0,
    NM_KERN  = 2'd1,
    NM_ALIAS = 2'd2,
    NM_HYP   = 2'd3
  } name_e;

  localparam logic [1:0] ENC_OP0      = 2'd3;
  localparam logic [3:0] ENC_CRN      = 4'd5;
  localparam logic [3:0] ENC_CRM      = 4'd6;
  localparam logic [2:0] ENC_OP2      = 3'd0;
  localparam logic [2:0] ENC_OP1_KERN = 3'd0;
  localparam logic [2:0] ENC_OP1_HYP  = 3'd4;
  localparam logic [2:0] ENC_OP1_ALS  = 3'd5;

  localparam int SYN_W = 6;
  localparam int OFF_W = 12;
  localparam logic [SYN_W-1:0] SYN_CLASS = 6'h18;
  localparam logic [OFF_W-1:0] REDIR_OFF = 12'h190;
endpackage

// File: rtl/tfs_decode.sv
module tfs_decode
  import tfs_pkg::*;
(
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output name_e      name
);
  logic base_hit;
  assign base_hit = (op0 == ENC_OP0) && (crn == ENC_CRN) &&
                    (crm == ENC_CRM) && (op2 == ENC_OP2);

  always_comb begin
    name = NM_NONE;
    if (base_hit) begin
      case (op1)
        ENC_OP1_KERN: name = NM_KERN;
        ENC_OP1_ALS:  name = NM_ALIAS;
        ENC_OP1_HYP:  name = NM_HYP;
        default:      name = NM_NONE;
      endcase
    end
  end
endmodule

// File: rtl/tfs_perm.sv
module tfs_perm
  import tfs_pkg::*;
(
  input  logic       valid,
  input  name_e      name,
  input  logic [1:0] lvl,
  input  logic       async_ok,
  input  logic       lvl3,
  input  logic       lvl2_en,
  input  logic       host,
  input  logic [2:0] nest,
  input  logic       htag,
  input  logic       mtag,
  input  logic       prio,
  input  logic       usel,
  output outcome_e   oc,
  output logic       tgt_hyp
);
  logic     prio_undef;
  logic     mon_hit;
  outcome_e mon_oc;
  logic     hv_trap;
  logic     nest_1x1;

  assign prio_undef = lvl3 && prio && !mtag;
  assign mon_hit    = lvl3 && !mtag;
  assign mon_oc     = (prio || usel) ? OC_UNDEF : OC_TRAP3;
  assign hv_trap    = lvl2_en && !host && !htag;
  assign nest_1x1   = nest[2] && nest[0];

  always_comb begin
    oc      = OC_UNDEF;
    tgt_hyp = 1'b0;
    if (!valid) begin
      oc = OC_IDLE;
    end else if (!async_ok || lvl == 2'd0 || name == NM_NONE) begin
      oc = OC_UNDEF;
    end else begin
      case (name)
        NM_KERN: begin
          if (lvl == 2'd1) begin
            if (prio_undef)             oc = OC_UNDEF;
            else if (nest == 3'b011)    oc = OC_TRAP2;
            else if (hv_trap)           oc = OC_TRAP2;
            else if (mon_hit)           oc = mon_oc;
            else if (nest == 3'b111)    oc = OC_REDIR;
            else                        oc = OC_DIRECT;
          end else if (lvl == 2'd2) begin
            if (mon_hit) oc = mon_oc;
            else begin
              oc      = OC_DIRECT;
              tgt_hyp = host;
            end
          end else begin
            oc = OC_DIRECT;
          end
        end
        NM_ALIAS: begin
          if (lvl == 2'd1) begin
            if (nest == 3'b101)  oc = OC_REDIR;
            else if (nest[0])    oc = OC_TRAP2;
            else                 oc = OC_UNDEF;
          end else if (lvl == 2'd2) begin
            if (!host)           oc = OC_UNDEF;
            else if (mon_hit)    oc = mon_oc;
            else                 oc = OC_DIRECT;
          end else begin
            oc = host ? OC_DIRECT : OC_UNDEF;
          end
        end
        NM_HYP: begin
          if (lvl == 2'd1) begin
            if (nest_1x1) begin
              if (prio_undef)    oc = OC_UNDEF;
              else if (hv_trap)  oc = OC_TRAP2;
              else if (mon_hit)  oc = mon_oc;
              else               oc = OC_DIRECT;
            end else if (nest[0]) oc = OC_TRAP2;
            else                  oc = OC_UNDEF;
          end else if (lvl == 2'd2) begin
            if (mon_hit) oc = mon_oc;
            else begin
              oc      = OC_DIRECT;
              tgt_hyp = 1'b1;
            end
          end else begin
            oc      = OC_DIRECT;
            tgt_hyp = 1'b1;
          end
        end
        default: oc = OC_UNDEF;
      endcase
    end
  end
endmodule

// File: rtl/tfs_flags.sv
module tfs_flags #(
  parameter int FW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_bits,
  input  logic [FW-1:0] set_bits,
  output logic [FW-1:0] q
);
  logic [FW-1:0] base;
  assign base = wr_en ? wr_bits : q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= base | set_bits;
  end
endmodule

// File: rtl/tfs_top.sv
module tfs_top
  import tfs_pkg::*;
#(
  parameter int DW = 64,
  parameter int FW = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flt_valid,
  input  logic                flt_addr55,
  input  logic                flt_sel,
  input  logic                req_valid,
  input  logic [1:0]          req_op0,
  input  logic [2:0]          req_op1,
  input  logic [3:0]          req_crn,
  input  logic [3:0]          req_crm,
  input  logic [2:0]          req_op2,
  input  logic                req_write,
  input  logic [DW-1:0]       req_wdata,
  input  logic [1:0]          cur_lvl,
  input  logic                cfg_async,
  input  logic                cfg_lvl3,
  input  logic                cfg_lvl2_en,
  input  logic                hyp_host,
  input  logic [2:0]          hyp_nest,
  input  logic                hyp_tag_en,
  input  logic                mon_tag_en,
  input  logic                mon_prio,
  input  logic                mon_undef_sel,
  output logic [2:0]          rsp_outcome,
  output logic [SYN_W-1:0]    rsp_syndrome,
  output logic [OFF_W-1:0]    rsp_redir_off,
  output logic [DW-1:0]       rsp_rdata
);
  localparam int NREG = 2;

  name_e    name;
  outcome_e oc;
  logic     tgt_hyp;
  logic     is_direct;
  logic [FW-1:0] flag_q [NREG];
  logic [FW-1:0] sel_q;

  tfs_decode u_dec (
    .op0 (req_op0), .op1 (req_op1), .crn (req_crn),
    .crm (req_crm), .op2 (req_op2), .name (name)
  );

  tfs_perm u_perm (
    .valid    (req_valid),
    .name     (name),
    .lvl      (cur_lvl),
    .async_ok (cfg_async),
    .lvl3     (cfg_lvl3),
    .lvl2_en  (cfg_lvl2_en),
    .host     (hyp_host),
    .nest     (hyp_nest),
    .htag     (hyp_tag_en),
    .mtag     (mon_tag_en),
    .prio     (mon_prio),
    .usel     (mon_undef_sel),
    .oc       (oc),
    .tgt_hyp  (tgt_hyp)
  );

  assign is_direct = (oc == OC_DIRECT);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic          wr_i;
    logic [FW-1:0] set_i;
    assign wr_i  = is_direct && req_write && (tgt_hyp == (i == 1));
    assign set_i = (flt_valid && (flt_sel == (i == 1)))
                   ? (flt_addr55 ? FW'(2'b10) : FW'(2'b01)) : '0;
    tfs_flags #(.FW(FW)) u_flags (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_i),
      .wr_bits  (req_wdata[FW-1:0]),
      .set_bits (set_i),
      .q        (flag_q[i])
    );
  end

  assign sel_q         = tgt_hyp ? flag_q[1] : flag_q[0];
  assign rsp_outcome   = oc;
  assign rsp_syndrome  = (oc == OC_TRAP2 || oc == OC_TRAP3) ? SYN_CLASS : '0;
  assign rsp_redir_off = (oc == OC_REDIR) ? REDIR_OFF : '0;
  assign rsp_rdata     = (is_direct && !req_write) ? {{(DW-FW){1'b0}}, sel_q} : '0;
endmodule

// File: rtl/tfs_chk.sv
module tfs_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          flt_valid,
  input logic          flt_addr55,
  input logic          flt_sel,
  input logic          req_valid,
  input logic          req_write,
  input logic [1:0]    cur_lvl,
  input logic          cfg_async,
  input logic [2:0]    rsp_outcome,
  input logic [5:0]    rsp_syndrome,
  input logic [11:0]   rsp_redir_off,
  input logic [DW-1:0] rsp_rdata,
  input logic [1:0]    kq,
  input logic [1:0]    hq
);
  logic dwr;
  assign dwr = req_valid && req_write && (rsp_outcome == 3'd5);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (rsp_outcome == 3'd0 && rsp_syndrome == 6'd0 &&
                    rsp_redir_off == 12'd0 && rsp_rdata == '0));
  // R2
  lvl0_undef_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (cur_lvl == 2'd0 || !cfg_async)) |-> rsp_outcome == 3'd1);
  // R7
  trap_syn_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_outcome == 3'd2 || rsp_outcome == 3'd3) |-> rsp_syndrome == 6'h18);
  // R7
  redir_off_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_outcome == 3'd4 |-> rsp_redir_off == 12'h190);
  // R8
  fault_set_chk: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && !flt_sel && flt_addr55) |=> kq[1]);
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (hq[0] && !dwr) |=> hq[0]);
  // R9
  no_touch_chk: assert property (@(posedge clk) disable iff (rst)
    (!dwr && !flt_valid) |=> ($stable(kq) && $stable(hq)));
endmodule

bind tfs_top tfs_chk #(.DW(DW)) u_chk (
  .clk (clk), .rst (rst), .flt_valid (flt_valid), .flt_addr55 (flt_addr55),
  .flt_sel (flt_sel), .req_valid (req_valid), .req_write (req_write),
  .cur_lvl (cur_lvl), .cfg_async (cfg_async), .rsp_outcome (rsp_outcome),
  .rsp_syndrome (rsp_syndrome), .rsp_redir_off (rsp_redir_off),
  .rsp_rdata (rsp_rdata), .kq (flag_q[0]), .hq (flag_q[1])
);

// File: tb/tfs_top_tb.sv
module tfs_top_tb;
  localparam int DW = 64;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flt_valid = 0, flt_addr55 = 0, flt_sel = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_op0 = 2'd3;
  logic [2:0] req_op1 = 3'd0;
  logic [3:0] req_crn = 4'd5, req_crm = 4'd6;
  logic [2:0] req_op2 = 3'd0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] cur_lvl = 2'd3;
  logic cfg_async = 1, cfg_lvl3 = 0, cfg_lvl2_en = 0, hyp_host = 0;
  logic [2:0] hyp_nest = 3'd0;
  logic hyp_tag_en = 0, mon_tag_en = 0, mon_prio = 0, mon_undef_sel = 0;
  logic [2:0] rsp_outcome;
  logic [5:0] rsp_syndrome;
  logic [11:0] rsp_redir_off;
  logic [DW-1:0] rsp_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tfs_top #(.DW(DW)) u_dut (.*);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model, name 0 kernel, 1 alias, 2 hypervisor
  function automatic int model(int lvl, int nm, logic [2:0] n, logic host, l2, ht,
                               mt, pr, us, l3, asy);
    logic mon, prio_u, hv;
    mon = l3 && !mt;
    prio_u = l3 && pr && !mt;
    hv = l2 && !host && !ht;
    if (!asy || lvl == 0) return 1;
    if (nm == 0) begin
      if (lvl == 3) return 5;
      if (lvl == 2) return mon ? ((pr || us) ? 1 : 3) : 5;
      if (prio_u) return 1;
      if (n == 3'b011 || hv) return 2;
      if (mon) return us ? 1 : 3;
      return (n == 3'b111) ? 4 : 5;
    end else if (nm == 1) begin
      if (lvl == 3) return host ? 5 : 1;
      if (lvl == 2) return !host ? 1 : (mon ? ((pr || us) ? 1 : 3) : 5);
      if (n == 3'b101) return 4;
      return n[0] ? 2 : 1;
    end else begin
      if (lvl == 3) return 5;
      if (lvl == 2) return mon ? ((pr || us) ? 1 : 3) : 5;
      if (n[2] && n[0]) begin
        if (prio_u) return 1;
        if (hv) return 2;
        if (mon) return us ? 1 : 3;
        return 5;
      end
      return n[0] ? 2 : 1;
    end
  endfunction

  task automatic access(int lvl, logic [2:0] op1, logic wr, logic [DW-1:0] d,
                        logic host, output logic [DW-1:0] rd);
    @(negedge clk);
    cfg_async = 1; cfg_lvl3 = 0; cfg_lvl2_en = 0; hyp_tag_en = 1; mon_tag_en = 1;
    cur_lvl = 2'(lvl); req_op1 = op1; req_write = wr; req_wdata = d;
    hyp_host = host; req_valid = 1;
    #1 rd = rsp_rdata;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic fault(logic sel, logic a55);
    @(negedge clk);
    flt_valid = 1; flt_sel = sel; flt_addr55 = a55;
    @(negedge clk);
    flt_valid = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    #1;
    chk("R11 idle outcome", rsp_outcome, 0);
    chk("R11 idle rdata", rsp_rdata, 0);
    access(3, 3'd0, 0, '0, 0, rd); chk("R11 reset kernel", rd, 0);
    access(3, 3'd4, 0, '0, 0, rd); chk("R11 reset hyp", rd, 0);

    // exhaustive outcome sweep, reads only
    for (int lvl = 0; lvl < 4; lvl++)
      for (int nm = 0; nm < 3; nm++)
        for (int cfg = 0; cfg < 2048; cfg++) begin
          int exp;
          logic [2:0] n;
          n = cfg[2:0];
          req_valid = 1; req_write = 0; cur_lvl = 2'(lvl);
          req_op1 = (nm == 0) ? 3'd0 : (nm == 1) ? 3'd5 : 3'd4;
          hyp_nest = n; hyp_host = cfg[3]; cfg_lvl2_en = cfg[4];
          hyp_tag_en = cfg[5]; mon_tag_en = cfg[6]; mon_prio = cfg[7];
          mon_undef_sel = cfg[8]; cfg_lvl3 = cfg[9]; cfg_async = cfg[10];
          #1;
          exp = model(lvl, nm, n, cfg[3], cfg[4], cfg[5], cfg[6], cfg[7],
                      cfg[8], cfg[9], cfg[10]);
          if (nm == 0) chk(lvl == 1 ? "R3 kernel chain" : "R4 kernel level2/3",
                           rsp_outcome, exp);
          else if (nm == 1) chk("R5 alias", rsp_outcome, exp);
          else chk("R6 hyp name", rsp_outcome, exp);
          if (!cfg[10] || lvl == 0) chk("R2 absent/level0", rsp_outcome, 1);
          chk("R7 syndrome", rsp_syndrome, (exp == 2 || exp == 3) ? 6'h18 : 0);
          chk("R7 offset", rsp_redir_off, (exp == 4) ? 12'h190 : 0);
        end
    req_valid = 0; mon_prio = 0; mon_undef_sel = 0;

    // decode misses
    @(negedge clk);
    cfg_async = 1; cfg_lvl3 = 0; cur_lvl = 3; req_valid = 1;
    req_op1 = 3'd1; #1 chk("R1 bad op1", rsp_outcome, 1);
    req_op1 = 3'd0; req_crm = 4'd7; #1 chk("R1 bad crm", rsp_outcome, 1);
    req_crm = 4'd6; req_op0 = 2'd2; #1 chk("R1 bad op0", rsp_outcome, 1);
    req_op0 = 2'd3; req_op2 = 3'd1; #1 chk("R1 bad op2", rsp_outcome, 1);
    req_op2 = 3'd0; req_crn = 4'd4; #1 chk("R1 bad crn", rsp_outcome, 1);
    req_crn = 4'd5; req_valid = 0;

    // flags
    fault(0, 1);
    access(3, 3'd0, 0, '0, 0, rd); chk("R8 kernel bit1", rd, 2);
    access(3, 3'd4, 0, '0, 0, rd); chk("R8 hyp untouched", rd, 0);
    fault(0, 0);
    access(3, 3'd0, 0, '0, 0, rd); chk("R8 accumulate", rd, 3);
    fault(1, 0);
    access(3, 3'd4, 0, '0, 0, rd); chk("R8 hyp bit0", rd, 1);
    access(3, 3'd0, 1, 64'hFFFF_FFFF_FFFF_FFFC, 0, rd);
    access(3, 3'd0, 0, '0, 0, rd); chk("R9 write upper ignored", rd, 0);
    access(3, 3'd0, 1, 64'h8000_0000_0000_0003, 0, rd);
    access(3, 3'd0, 0, '0, 0, rd); chk("R9 write load", rd, 3);
    // trapped write has no effect: level 1, nested 011
    @(negedge clk);
    cfg_async = 1; cfg_lvl3 = 0; cur_lvl = 1; req_op1 = 3'd0; hyp_nest = 3'b011;
    req_write = 1; req_wdata = '0; req_valid = 1;
    #1 chk("R9 trapped write rdata", rsp_rdata, 0);
    @(negedge clk); req_valid = 0; req_write = 0; hyp_nest = 0;
    access(3, 3'd0, 0, '0, 0, rd); chk("R9 trapped write ignored", rd, 3);
    // level 2 host remap writes hyp register
    access(2, 3'd0, 1, 64'h2, 1, rd);
    access(3, 3'd4, 0, '0, 0, rd); chk("R4 host remap to hyp", rd, 2);
    access(3, 3'd0, 0, '0, 0, rd); chk("R4 kernel kept", rd, 3);
    // merge
    @(negedge clk);
    cur_lvl = 3; req_op1 = 3'd0; req_write = 1; req_wdata = '0; req_valid = 1;
    flt_valid = 1; flt_sel = 0; flt_addr55 = 1;
    @(negedge clk); req_valid = 0; req_write = 0; flt_valid = 0;
    access(3, 3'd0, 0, '0, 0, rd); chk("R10 merge after write", rd, 2);
    // reset clears
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    access(3, 3'd4, 0, '0, 0, rd); chk("R11 reset clears hyp", rd, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule